// File: doc/BRIEF.md
# Push-Pull Pulse Steering Logic

This block sits between the PWM comparator of a switch-mode controller and its two power drivers. It accepts a raw compare signal that may chatter or cross the ramp more than once in a period. It lets through at most one pulse per oscillator period and sends successive pulses to the two drivers in strict alternation. The block runs on a fast system clock. Each input is digital but unrelated to that clock, so every input first passes through a multi-flop synchronizer.

A sync pulse marks the start of each oscillator period and arms a metering state machine. The gated compare signal then passes through until it falls for the first time; after that the path stays closed until the next sync. A memory flop records whether a pulse passed. At the next sync the driver phase flips only if one did, so a period with no pulse can never make the same driver fire twice in a row. A blanking pulse, an active-low shutdown input and an undervoltage flag all hold both drivers off. A parameter selects whether the active driver level is high or low.

The metering state machine has four states. ST_WAIT is the disarmed state after reset. ST_ARMED waits for the gated compare. ST_PASS means a pulse is passing. ST_SPENT means the period's pulse is over. Its transitions are: T_ARM (any state to ST_ARMED on sync), T_OPEN (ST_ARMED to ST_PASS when the gated compare is high), T_CLOSE (ST_PASS to ST_SPENT when it falls), and T_HOLD (stay put otherwise).

Top module: `pps_steer`

## Requirements
- R1: The compare input is qualified by the shutdown input (active low), the blanking input and the lockout flag before metering. A low shutdown ends a passing pulse in the same cycle it reaches the metering logic, and that ended pulse counts as the period's one pulse.
- R2: After reset no pulse passes until the first sync pulse has been seen, even with the compare input held high.
- R3: Once a passed pulse has ended, no further pulse reaches either driver until the next sync, however often the compare input rises again.
- R4: The driver phase changes only at a sync, and only if a pulse passed during the period that sync ends. A period with no passed pulse leaves the phase unchanged.
- R5: Successive pulses go to driver A and driver B alternately; the two are never active together; reset puts the phase on driver A.
- R6: While blanking is high, both drivers are inactive and no pulse can open.
- R7: While the lockout flag is high, both drivers are inactive and no pulse can open.
- R8: With ACTIVE_HIGH = 1 an active driver is 1 and an idle one 0; with ACTIVE_HIGH = 0 the levels are inverted.
- R9: An input change reaches the driver outputs on the (SYNC_STAGES + 1)-th rising clock edge after it is sampled. This is 3 edges with the default of two synchronizer stages.
- R10: During and right after reset both outputs hold the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Period-start pulse from the oscillator |
| blank_i | input | 1 | Deadtime blanking, high holds drivers off |
| pwm_i | input | 1 | Raw PWM compare result |
| shdn_n_i | input | 1 | Shutdown / current limit, low blocks pulses |
| uvlo_i | input | 1 | Undervoltage lockout, high inhibits drivers |
| drv_a_o | output | 1 | Driver A, level per ACTIVE_HIGH |
| drv_b_o | output | 1 | Driver B, level per ACTIVE_HIGH |

## Verification
A metering state stuck open shows up at the ports in the same period: a second pulse appears on a driver after the compare signal re-crosses. A memory flop that ignores the missing-pulse case shows up one period later, when the same driver fires twice in a row after a shut-down period. A wrong reset phase shows up on the very first pulse after reset. Each of these faults becomes visible three clock edges after the stimulus that exposes it.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PASS  = 2'd2,
        ST_SPENT = 2'd3
    } meter_st_t;

    localparam int unsigned NUM_IN = 5;

endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pps_meter.sv
module pps_meter
    import pps_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      gate,
    output logic      pass,
    output logic      fired,
    output meter_st_t st
);
    meter_st_t st_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_WAIT;
        else        st <= st_nx;
    end

    // next state and pass-through output
    always_comb begin
        st_nx = st;
        pass  = 1'b0;
        if (start) begin
            st_nx = ST_ARMED;                     // T_ARM
        end else begin
            unique case (st)
                ST_WAIT:  st_nx = ST_WAIT;        // T_HOLD
                ST_ARMED: begin
                    if (gate) begin
                        st_nx = ST_PASS;          // T_OPEN
                        pass  = 1'b1;
                    end
                end
                ST_PASS: begin
                    if (gate) pass  = 1'b1;
                    else      st_nx = ST_SPENT;   // T_CLOSE
                end
                ST_SPENT: st_nx = ST_SPENT;       // T_HOLD
                default:  st_nx = ST_WAIT;
            endcase
        end
    end

    // memory flop: a pulse passed during the current period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     fired <= 1'b0;
        else if (start) fired <= 1'b0;
        else if (pass)  fired <= 1'b1;
    end
endmodule

// File: rtl/pps_phase.sv
module pps_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fired,
    output logic phase
);
    // phase 0 selects driver A, 1 selects driver B
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase <= 1'b0;
        else if (start && fired) phase <= ~phase;
    end
endmodule

// File: rtl/pps_outgate.sv
module pps_outgate #(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pass,
    input  logic phase,
    output logic drv_a,
    output logic drv_b
);
    localparam logic IDLE_LVL = ACTIVE_HIGH ? 1'b0 : 1'b1;

    logic act_a;
    logic act_b;

    always_comb begin
        act_a = pass & ~phase;
        act_b = pass &  phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_a <= IDLE_LVL;
            drv_b <= IDLE_LVL;
        end else begin
            drv_a <= act_a ^ IDLE_LVL;
            drv_b <= act_b ^ IDLE_LVL;
        end
    end
endmodule

// File: rtl/pps_steer.sv
module pps_steer
    import pps_pkg::*;
#(
    parameter bit          ACTIVE_HIGH = 1'b1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic blank_i,
    input  logic pwm_i,
    input  logic shdn_n_i,
    input  logic uvlo_i,
    output logic drv_a_o,
    output logic drv_b_o
);
    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] syn_in;
    logic s_sync, s_blank, s_pwm, s_shdn_n, s_uvlo;
    logic gate, pass, fired, phase;
    meter_st_t st;

    assign raw_in = {sync_i, blank_i, pwm_i, shdn_n_i, uvlo_i};

    pps_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
    );

    assign {s_sync, s_blank, s_pwm, s_shdn_n, s_uvlo} = syn_in;

    // qualified compare: shutdown, blanking and lockout all close it
    assign gate = s_pwm & s_shdn_n & ~s_blank & ~s_uvlo;

    pps_meter u_meter (
        .clk(clk), .rst_n(rst_n), .start(s_sync), .gate(gate),
        .pass(pass), .fired(fired), .st(st)
    );

    pps_phase u_phase (
        .clk(clk), .rst_n(rst_n), .start(s_sync), .fired(fired), .phase(phase)
    );

    pps_outgate #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_out (
        .clk(clk), .rst_n(rst_n), .pass(pass), .phase(phase),
        .drv_a(drv_a_o), .drv_b(drv_b_o)
    );
endmodule

// File: rtl/pps_steer_chk.sv
module pps_steer_chk
    import pps_pkg::*;
#(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input logic      clk,
    input logic      rst_n,
    input logic      s_sync,
    input logic      s_blank,
    input logic      s_uvlo,
    input logic      gate,
    input logic      pass,
    input logic      fired,
    input logic      phase,
    input meter_st_t st,
    input logic      drv_a,
    input logic      drv_b
);
    logic on_a, on_b;
    assign on_a = ACTIVE_HIGH ? drv_a : ~drv_a;
    assign on_b = ACTIVE_HIGH ? drv_b : ~drv_b;

    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> !pass); // R1
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && !s_sync) |=> (st == ST_WAIT)); // R2
    AST_SPENT_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SPENT) |-> !pass); // R3
    AST_PHASE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_sync || !fired) |=> $stable(phase)); // R4
    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_sync && fired) |=> (phase != $past(phase))); // R4
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(on_a && on_b)); // R5
    AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        s_blank |=> (!on_a && !on_b)); // R6
    AST_UVLO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        s_uvlo |=> (!on_a && !on_b)); // R7
endmodule

bind pps_steer pps_steer_chk #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_sync(s_sync), .s_blank(s_blank),
    .s_uvlo(s_uvlo), .gate(gate), .pass(pass), .fired(fired),
    .phase(phase), .st(st), .drv_a(drv_a_o), .drv_b(drv_b_o)
);

// File: tb/tb_pps_steer.sv
module tb_pps_steer;
    localparam time CLK_PERIOD = 10ns;
    localparam int  LAT = 3;   // sample-before-drive offset: 2 sync flops + output reg
    localparam int  N = 38;

    // row bits: [7] rst  [6] sync [5] blank [4] pwm [3] shdn_n [2] uvlo [1] expA [0] expB
    localparam logic [7:0] VEC [N] = '{
        8'b0_1_1_0_1_0_00, // 0  R9 normal period, sync
        8'b0_0_0_0_1_0_00, // 1
        8'b0_0_0_1_1_0_10, // 2  pulse on A
        8'b0_0_0_1_1_0_10, // 3
        8'b0_0_0_0_1_0_00, // 4
        8'b0_0_0_0_1_0_00, // 5
        8'b0_1_1_0_1_0_00, // 6  R1 shutdown chop, phase to B
        8'b0_0_0_1_1_0_01, // 7
        8'b0_0_0_1_0_0_00, // 8  shutdown low ends pulse
        8'b0_0_0_1_1_0_00, // 9  shutdown back, stays blocked
        8'b0_0_0_0_1_0_00, // 10
        8'b0_1_1_0_0_0_00, // 11 R4 whole period shut down
        8'b0_0_0_1_0_0_00, // 12
        8'b0_0_0_1_0_0_00, // 13
        8'b0_0_0_0_0_0_00, // 14
        8'b0_1_1_0_1_0_00, // 15 R3 phase held (no pulse) -> A
        8'b0_0_0_1_1_0_10, // 16
        8'b0_0_0_0_1_0_00, // 17
        8'b0_0_0_1_1_0_00, // 18 re-crossing blocked
        8'b0_0_0_0_1_0_00, // 19
        8'b0_0_0_1_1_0_00, // 20 re-crossing blocked
        8'b0_1_1_0_1_0_00, // 21 R6 blanking, phase to B
        8'b0_0_1_1_1_0_00, // 22 compare high under blank
        8'b0_0_0_1_1_0_01, // 23
        8'b0_0_1_1_1_0_00, // 24 blank closes pulse
        8'b0_0_0_1_1_0_00, // 25 blocked
        8'b0_1_1_0_1_0_00, // 26 R7 lockout, phase to A
        8'b0_0_0_1_1_1_00, // 27
        8'b0_0_0_1_1_0_10, // 28
        8'b0_0_0_1_1_1_00, // 29
        8'b0_0_0_0_1_0_00, // 30
        8'b0_0_0_0_1_0_00, // 31 R5 reset restores phase A
        8'b1_0_0_0_1_0_00, // 32 reset row
        8'b0_1_1_0_1_0_00, // 33
        8'b0_0_0_1_1_0_10, // 34 A again (B without reset)
        8'b0_0_0_0_1_0_00, // 35
        8'b0_0_0_0_1_0_00, // 36
        8'b0_0_0_0_1_0_00  // 37
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_i = 1'b0, blank_i = 1'b0, pwm_i = 1'b0, shdn_n_i = 1'b1, uvlo_i = 1'b0;
    logic drv_a_o, drv_b_o, inv_a_o, inv_b_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pps_steer #(.ACTIVE_HIGH(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .blank_i(blank_i),
        .pwm_i(pwm_i), .shdn_n_i(shdn_n_i), .uvlo_i(uvlo_i),
        .drv_a_o(drv_a_o), .drv_b_o(drv_b_o)
    );

    pps_steer #(.ACTIVE_HIGH(1'b0)) dut_inv (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .blank_i(blank_i),
        .pwm_i(pwm_i), .shdn_n_i(shdn_n_i), .uvlo_i(uvlo_i),
        .drv_a_o(inv_a_o), .drv_b_o(inv_b_o)
    );

    function automatic string tag_of(int idx);
        if (idx <= 5)  return "R9";
        if (idx <= 10) return "R1";
        if (idx <= 14) return "R4";
        if (idx <= 20) return "R3";
        if (idx <= 25) return "R6";
        if (idx <= 30) return "R7";
        return "R5";
    endfunction

    task automatic check(string tag, int idx, logic [1:0] got, logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s step %0d: got AB=%b exp AB=%b", tag, idx, got, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL R9 watchdog: got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: outputs inactive during reset
        repeat (3) @(negedge clk);
        check("R10", -1, {drv_a_o, drv_b_o}, 2'b00);
        check("R10", -1, {inv_a_o, inv_b_o}, 2'b11);
        rst_n = 1'b1;

        // R2: compare held high with no sync since reset
        pwm_i = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R2", k, {drv_a_o, drv_b_o}, 2'b00);
            check("R10", k, {inv_a_o, inv_b_o}, 2'b11);
        end

        // table walk: sample before driving each step
        for (int i = 0; i < N + LAT; i++) begin
            @(negedge clk);
            if (i >= LAT) begin
                logic [1:0] e;
                e = VEC[i-LAT][1:0];
                check(tag_of(i-LAT), i-LAT, {drv_a_o, drv_b_o}, e);
                check("R8", i-LAT, {inv_a_o, inv_b_o}, ~e);
            end
            if (i < N) begin
                rst_n    = ~VEC[i][7];
                sync_i   = VEC[i][6];
                blank_i  = VEC[i][5];
                pwm_i    = VEC[i][4];
                shdn_n_i = VEC[i][3];
                uvlo_i   = VEC[i][2];
            end else begin
                rst_n = 1'b1; sync_i = 1'b0; blank_i = 1'b0;
                pwm_i = 1'b0; shdn_n_i = 1'b1; uvlo_i = 1'b0;
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule